// File: doc/BRIEF.md
# Unaligned Store Lane Generator

This block turns the four partial-word unaligned store operations (word-left, word-right, doubleword-left, doubleword-right) into one write on a 64-bit memory bus. For each request it produces the write address, the number of bytes written, an 8-bit byte-enable mask and lane-aligned write data. The left forms write from the given address up to the end of the word or doubleword and take the most significant register bytes. The right forms write from the aligned word or doubleword start up to and including the addressed byte and take the least significant register bytes. So the byte count moves in opposite directions with the low address bits.

None of these writes carries a capability. Each one therefore raises a tag-clear request for the 32-byte tag granule that holds the write address. The lanes are big-endian: bus lane L is address offset L within the doubleword and occupies data bits [63-8L -: 8]. The most significant selected register byte goes to the lowest addressed lane. An optional output register, chosen by parameter, adds one cycle of latency. Otherwise the result appears in the same cycle as the request.

Operation code on `req_op`: 2'b00 word-left, 2'b01 word-right, 2'b10 doubleword-left, 2'b11 doubleword-right.

Top module: `ulst_store_lanes`

## Requirements
- R1: Word-left with address offset o = addr[1:0] writes 4-o bytes in lanes addr[2:0] up to addr[2:0]+3-o, with out_addr equal to the request address.
- R2: Word-left data takes register bits 31 down to 8o, and register byte 3 lands in lane addr[2:0].
- R3: Word-right clears addr[1:0] in out_addr and writes o+1 bytes in lanes {addr[2],2'b00} onward, taken from register bits 8o+7 down to 0, with register byte o in the first lane.
- R4: Doubleword-left with k = addr[2:0] writes 8-k bytes in lanes k to 7, taken from register bits 63 down to 8k, with out_addr equal to the request address.
- R5: Doubleword-right clears addr[2:0] in out_addr and writes k+1 bytes in lanes 0 to k, taken from register bits 8k+7 down to 0, with register byte k in lane 0.
- R6: For every valid write, out_be has exactly out_count bits set, and they form one contiguous run.
- R7: Every valid write raises out_tag_clr, and out_tag_addr is out_addr with its low GRAN_LG (default 5) bits cleared.
- R8: Data bytes in disabled lanes are zero. With no valid request, out_be, out_count, out_data and out_tag_clr are all zero.
- R9: With OUT_REG=1 (the default), the outputs reflect the request from the previous clock edge. Reset, which is active low, clears out_valid and every other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Store form: 00 word-left, 01 word-right, 10 dword-left, 11 dword-right |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | 64 | Register value |
| out_valid | output | 1 | Write present |
| out_addr | output | ADDR_W | Write address, realigned for right forms |
| out_count | output | 4 | Number of bytes written (1 to 8) |
| out_be | output | 8 | Byte enables, bit L for lane L |
| out_data | output | 64 | Lane-aligned write data, lane L at bits [63-8L -: 8] |
| out_tag_clr | output | 1 | Tag-clear request for a non-capability write |
| out_tag_addr | output | ADDR_W | Granule address whose tag is cleared |

## Verification
The assertions check the invariants that hold on every cycle. The enable count matches out_count and forms one contiguous run. Disabled lanes carry zero data. Tag-clear follows every write at the aligned granule. Idle cycles stay quiet. Word forms stay inside one 4-lane half, and the doubleword forms reach lane 7 or lane 0 as their direction requires. Which register bytes land in which lanes, and the address realignment for each operation at each of the eight offsets, can only be shown by the bench's scenarios. These compare every field against a shift-based model over all offsets and several data patterns.

// File: rtl/ulst_pkg.sv
package ulst_pkg;

  localparam int BUS_BYTES = 8;
  localparam int LANE_LG   = $clog2(BUS_BYTES);
  localparam int CNT_W     = LANE_LG + 1;
  localparam int DATA_W    = BUS_BYTES * 8;

  typedef enum logic [1:0] {
    ST_WL = 2'b00,
    ST_WR = 2'b01,
    ST_DL = 2'b10,
    ST_DR = 2'b11
  } st_op_e;

  // Geometry of one write: first lane, byte count, register byte that
  // lands in the first lane, and number of address bits to clear.
  typedef struct packed {
    logic [LANE_LG-1:0] start;
    logic [CNT_W-1:0]   count;
    logic [LANE_LG-1:0] top;
    logic [1:0]         align_lg;
  } lane_plan_t;

  function automatic lane_plan_t plan_for(st_op_e op, logic [LANE_LG-1:0] off);
    lane_plan_t p;
    p = '0;
    case (op)
      ST_WL: begin
        p.start    = off;
        p.count    = CNT_W'(4) - CNT_W'(off[1:0]);
        p.top      = LANE_LG'(3);
        p.align_lg = 2'd0;
      end
      ST_WR: begin
        p.start    = {off[2], 2'b00};
        p.count    = CNT_W'(off[1:0]) + CNT_W'(1);
        p.top      = {1'b0, off[1:0]};
        p.align_lg = 2'd2;
      end
      ST_DL: begin
        p.start    = off;
        p.count    = CNT_W'(BUS_BYTES) - CNT_W'(off);
        p.top      = LANE_LG'(BUS_BYTES - 1);
        p.align_lg = 2'd0;
      end
      default: begin
        p.start    = '0;
        p.count    = CNT_W'(off) + CNT_W'(1);
        p.top      = off;
        p.align_lg = 2'd3;
      end
    endcase
    return p;
  endfunction

  // Source register byte feeding a lane inside the run.
  function automatic logic [LANE_LG-1:0] src_byte(lane_plan_t p, logic [LANE_LG-1:0] lane);
    return p.top + p.start - lane;
  endfunction

  function automatic logic lane_in_run(lane_plan_t p, logic [LANE_LG-1:0] lane);
    logic [CNT_W-1:0] pos;
    logic [CNT_W-1:0] lo;
    pos = {1'b0, lane};
    lo  = {1'b0, p.start};
    return (pos >= lo) && (pos < lo + p.count);
  endfunction

endpackage

// File: rtl/ulst_plan.sv
module ulst_plan
  import ulst_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              valid,
  input  st_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  output lane_plan_t        plan,
  output logic [ADDR_W-1:0] wr_addr
);

  lane_plan_t raw;
  logic [ADDR_W-1:0] clr_mask;

  always_comb begin
    raw = plan_for(op, addr[LANE_LG-1:0]);
    clr_mask = '1;
    case (raw.align_lg)
      2'd2:    clr_mask[1:0] = 2'b00;
      2'd3:    clr_mask[2:0] = 3'b000;
      default: clr_mask = '1;
    endcase
    wr_addr = addr & clr_mask;
    plan = valid ? raw : '0;
  end

endmodule

// File: rtl/ulst_lane_steer.sv
module ulst_lane_steer
  import ulst_pkg::*;
(
  input  lane_plan_t          plan,
  input  logic [DATA_W-1:0]   reg_data,
  output logic [BUS_BYTES-1:0] be,
  output logic [DATA_W-1:0]   lane_data
);

  for (genvar gl = 0; gl < BUS_BYTES; gl++) begin : g_lane
    localparam int LO_BIT = 8 * (BUS_BYTES - 1 - gl);
    logic [LANE_LG-1:0] src;
    logic               hit;
    always_comb begin
      hit = lane_in_run(plan, LANE_LG'(gl));
      src = src_byte(plan, LANE_LG'(gl));
      be[gl] = hit;
      lane_data[LO_BIT +: 8] = hit ? reg_data[{src, 3'b000} +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/ulst_out_stage.sv
module ulst_out_stage #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/ulst_store_lanes.sv
module ulst_store_lanes
  import ulst_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int GRAN_LG = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_data,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic [3:0]           out_count,
  output logic [7:0]           out_be,
  output logic [63:0]          out_data,
  output logic                 out_tag_clr,
  output logic [ADDR_W-1:0]    out_tag_addr
);

  localparam int PACK_W = 1 + ADDR_W + CNT_W + BUS_BYTES + DATA_W + 1 + ADDR_W;

  // Named internal events, visible to waveform and checker alike.
  lane_plan_t               plan_w;
  logic [ADDR_W-1:0]        wr_addr_w;
  logic [BUS_BYTES-1:0]     be_w;
  logic [DATA_W-1:0]        lane_data_w;
  logic                     tag_clr_w;
  logic [ADDR_W-1:0]        tag_addr_w;
  logic [PACK_W-1:0]        pack_d;
  logic [PACK_W-1:0]        pack_q;

  ulst_plan #(.ADDR_W(ADDR_W)) u_plan (
    .valid   (req_valid),
    .op      (st_op_e'(req_op)),
    .addr    (req_addr),
    .plan    (plan_w),
    .wr_addr (wr_addr_w)
  );

  ulst_lane_steer u_steer (
    .plan      (plan_w),
    .reg_data  (req_data),
    .be        (be_w),
    .lane_data (lane_data_w)
  );

  always_comb begin
    tag_clr_w  = req_valid;
    tag_addr_w = {wr_addr_w[ADDR_W-1:GRAN_LG], {GRAN_LG{1'b0}}};
    pack_d = {req_valid,
              req_valid ? wr_addr_w : '0,
              plan_w.count,
              be_w,
              lane_data_w,
              tag_clr_w,
              req_valid ? tag_addr_w : '0};
  end

  ulst_out_stage #(.WIDTH(PACK_W), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pack_d),
    .q     (pack_q)
  );

  assign {out_valid, out_addr, out_count, out_be, out_data,
          out_tag_clr, out_tag_addr} = pack_q;

endmodule

// File: rtl/ulst_store_lanes_chk.sv
module ulst_store_lanes_chk #(
  parameter int ADDR_W  = 64,
  parameter int GRAN_LG = 5,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [3:0]        out_count,
  input logic [7:0]        out_be,
  input logic [63:0]       out_data,
  input logic              out_tag_clr,
  input logic [ADDR_W-1:0] out_tag_addr
);

  function automatic logic [63:0] expand_be(logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[8*(7-i) +: 8] = {8{be[i]}};
    return m;
  endfunction

  a_r6_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_be) == int'(out_count)) && (out_count != 4'd0));

  a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_be ^ (out_be >> 1)) <= 2);

  a_r8_dead_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data & ~expand_be(out_be)) == 64'h0);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_be == 8'h00) && !out_tag_clr && (out_count == 4'd0));

  a_r7_tag_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tag_clr &&
      (out_tag_addr[GRAN_LG-1:0] == '0) &&
      (out_tag_addr[ADDR_W-1:GRAN_LG] == out_addr[ADDR_W-1:GRAN_LG]));

  if (OUT_REG) begin : g_seq
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(req_valid));

    a_r1_word_half: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(req_op[1])) |->
        (out_count <= 4'd4) && ((out_be[7:4] == 4'h0) || (out_be[3:0] == 4'h0)));

    a_r4_dl_reaches_end: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($past(req_op) == 2'b10)) |-> out_be[7]);

    a_r5_dr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ($past(req_op) == 2'b11)) |-> out_be[0] && (out_addr[2:0] == 3'b000));
  end

endmodule

bind ulst_store_lanes ulst_store_lanes_chk #(
  .ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .out_valid(out_valid), .out_addr(out_addr), .out_count(out_count),
  .out_be(out_be), .out_data(out_data), .out_tag_clr(out_tag_clr),
  .out_tag_addr(out_tag_addr)
);

// File: tb/ulst_store_lanes_test.sv
`timescale 1ns/1ps
module ulst_store_lanes_test;

  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [63:0]   req_data = '0;
  logic          out_valid;
  logic [AW-1:0] out_addr;
  logic [3:0]    out_count;
  logic [7:0]    out_be;
  logic [63:0]   out_data;
  logic          out_tag_clr;
  logic [AW-1:0] out_tag_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic          valid;
    logic [AW-1:0] addr;
    logic [3:0]    count;
    logic [7:0]    be;
    logic [63:0]   data;
    logic          tclr;
    logic [AW-1:0] taddr;
    string         geo_req;
    string         dat_req;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  ulst_store_lanes uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .out_valid(out_valid),
    .out_addr(out_addr), .out_count(out_count), .out_be(out_be),
    .out_data(out_data), .out_tag_clr(out_tag_clr), .out_tag_addr(out_tag_addr)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference: place the slice by shifting a whole register, then mask.
  function automatic exp_t model(logic v, logic [1:0] op, logic [AW-1:0] a, logic [63:0] r);
    exp_t e;
    int s, n, k, o;
    logic [63:0] src;
    k = int'(a[2:0]);
    o = int'(a[1:0]);
    e.valid = v; e.addr = a; e.tclr = v;
    case (op)
      2'b00: begin s = k; n = 4 - o; src = {r[31:0], 32'h0} >> (8*s);
                   e.geo_req = "R1"; e.dat_req = "R2"; end
      2'b01: begin s = 4 * int'(a[2]); n = o + 1; src = (r << (8*(7-o))) >> (8*s);
                   e.addr = {a[AW-1:2], 2'b00}; e.geo_req = "R3"; e.dat_req = "R3"; end
      2'b10: begin s = k; n = 8 - k; src = r >> (8*k);
                   e.geo_req = "R4"; e.dat_req = "R4"; end
      default: begin s = 0; n = k + 1; src = r << (8*(7-k));
                   e.addr = {a[AW-1:3], 3'b000}; e.geo_req = "R5"; e.dat_req = "R5"; end
    endcase
    e.be = '0;
    e.data = '0;
    for (int l = 0; l < 8; l++) begin
      if (l >= s && l < s + n) begin
        e.be[l] = 1'b1;
        e.data[8*(7-l) +: 8] = src[8*(7-l) +: 8];
      end
    end
    e.count = 4'(n);
    e.taddr = {e.addr[AW-1:5], 5'b0};
    if (!v) begin
      e.addr = '0; e.count = '0; e.be = '0; e.data = '0; e.taddr = '0;
      e.geo_req = "R8"; e.dat_req = "R8";
    end
    return e;
  endfunction

  task automatic drive(logic v, logic [1:0] op, logic [AW-1:0] a, logic [63:0] r);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a; req_data = r;
    q.push_back(model(v, op, a, r));
  endtask

  // Monitor: one expected item per cycle, one register of latency (R9).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check("R9", "valid", 64'(out_valid), 64'(e.valid));
        check(e.geo_req, "addr", out_addr, e.addr);
        check(e.geo_req, "count", 64'(out_count), 64'(e.count));
        check(e.geo_req, "be", 64'(out_be), 64'(e.be));
        check(e.dat_req, "data", out_data, e.data);
        check("R7", "tag_clr", 64'(out_tag_clr), 64'(e.tclr));
        check("R7", "tag_addr", out_tag_addr, e.taddr);
        check("R6", "be_count", 64'($countones(out_be)), 64'(out_count));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'h0011_2233_4455_6677;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h8001_4002_2004_1008;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset valid", 64'(out_valid), 64'h0);
    check("R9", "reset be", 64'(out_be), 64'h0);
    check("R9", "reset data", out_data, 64'h0);
    rst_n = 1'b1;
    drive(1'b0, 2'b00, '0, '0);
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int off = 0; off < 8; off++) begin
          logic [AW-1:0] a;
          a = {$urandom(), $urandom()};
          a[2:0] = 3'(off);
          drive(1'b1, 2'(op), a, pats[p]);
        end
        // R8: idle cycle with live-looking inputs must stay quiet
        drive(1'b0, 2'(op), 64'h1234_5678_9ABC_DEF5, pats[p]);
      end
    end
    // Back-to-back random requests
    for (int i = 0; i < 64; i++) begin
      drive(1'b1, 2'($urandom_range(3)), {$urandom(), $urandom()}, {$urandom(), $urandom()});
    end
    drive(1'b0, 2'b00, '0, '0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule